// File: doc/BRIEF.md
# Serial Decimal Sample Streamer with Software Flow Control

This block takes a stream of captured sample words and sends each one out on an asynchronous serial transmit line as readable text. Every word's raw bit pattern is read as an unsigned number and sent as decimal ASCII digits, most significant digit first, with no leading zeros. Each value is followed by a carriage return. A 12-bit two's complement negative full-scale sample (bit pattern 0x800) therefore appears on the line as the characters "2048" and then CR.

The same serial port's receive line is watched for in-band software flow control. A received XOFF byte stops any new character from starting. A received XON byte lets output continue. A character that is already being shifted out always finishes. After reset, output is enabled, just as if XON had been received. Words enter through a valid/ready handshake. The word flagged as last raises a sticky done flag once its carriage return has fully left the transmitter. One clock divider produces a 16x oversampling tick from the system clock and baud-rate parameters. The receiver and the transmitter both run from that tick.

Top module: `sample_streamer`

## Requirements
- R1: Each character is framed as follows: idle high, one low start bit, 8 data bits least significant bit first, one high stop bit, and no parity. Every bit lasts 16 oversampling ticks, where one tick is CLK_HZ/(BAUD*16) clocks, rounded down.
- R2: A word is sent as the decimal text of its unsigned value, most significant digit first. Digit d is sent as the byte 0x30+d. Leading zeros are never sent. The maximum 18-bit word 262143 is sent as six digits.
- R3: A word of value zero is sent as the single character "0" (0x30).
- R4: Every value is followed by exactly one carriage return byte, 0x0D.
- R5: A word is accepted on a clock edge where wordValid and wordReady are both high. Words are sent in the order they were accepted, with none dropped or repeated. wordReady goes low in the cycle after an acceptance.
- R6: After a received 0x13 byte, no new character starts. A character already being sent completes with a correct stop bit.
- R7: After a received 0x11 byte, pending characters start to flow again.
- R8: After reset, output is enabled without any byte having been received.
- R9: Any received byte other than 0x11 or 0x13 has no effect on the flow state.
- R10: The receiver checks the start bit again half a bit time after the falling edge. A low pulse shorter than that is discarded, and it does not disturb the reception of a byte that follows it.
- R11: done goes high only after the stop bit of the carriage return for the word accepted with wordLast high has ended. It then stays high, and wordReady stays low, until reset.
- R12: During and right after reset, txLine is high, done is low and wordReady is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wordValid | input | 1 | Input word is valid |
| wordData | input | WORD_W | Sample word, read as unsigned |
| wordLast | input | 1 | Marks the final word of the stream |
| wordReady | output | 1 | Block can accept a word this cycle |
| rxLine | input | 1 | Serial receive line (flow control bytes) |
| txLine | output | 1 | Serial transmit line |
| done | output | 1 | Final word's carriage return has left the line |

## Verification
The bench builds the block with CLK_HZ=1600000 and BAUD=100000. With these values the oversampling divider is 1 and one bit lasts exactly 16 clocks. Several hundred characters therefore fit in the cycle budget, and the bench can place receive-side glitches and flow-control bytes at exact tick positions. WORD_W stays at its default of 18. This lets the bench reach the six-digit maximum 262143, zero, and every digit-count boundary, alongside random words of random bit length.

// File: rtl/streamer_pkg.sv
package streamer_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadWord;
    logic dabbleStep;
    logic shiftDigit;
    logic sendDigit;
    logic sendCr;
  } strobe_t;

  // Decimal digits needed for a w-bit unsigned value
  function automatic int digitsFor(input int w);
    return (w * 1233) / 4096 + 1;
  endfunction

endpackage

// File: rtl/streamer_dp.sv
module streamer_dp
  import streamer_pkg::*;
#(
  parameter int WORD_W   = 18,
  parameter int NDIG     = 6,
  parameter int TICK_DIV = 108,
  parameter int OVS      = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [WORD_W-1:0] wordData,
  input  logic              rxLine,
  output logic              txLine,
  output logic              txBusy,
  output logic              flowOn,
  output logic [3:0]        topDigit
);

  localparam int CW = $clog2(TICK_DIV + 1);
  localparam int PW = $clog2(OVS);
  localparam int BW = NDIG * 4;

  // Oversampling tick
  logic [CW-1:0] tickCnt;
  logic          tick;
  assign tick = (tickCnt == CW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     tickCnt <= '0;
    else if (tick) tickCnt <= '0;
    else           tickCnt <= tickCnt + 1'b1;
  end

  // Binary to BCD by shift-and-add-3
  logic [BW-1:0]     bcd;
  logic [BW-1:0]     bcdAdj;
  logic [WORD_W-1:0] bin;

  for (genvar g = 0; g < NDIG; g++) begin : gAdj
    assign bcdAdj[g*4 +: 4] = (bcd[g*4 +: 4] >= 4'd5) ? bcd[g*4 +: 4] + 4'd3
                                                      : bcd[g*4 +: 4];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bcd <= '0;
      bin <= '0;
    end else if (stb.loadWord) begin
      bcd <= '0;
      bin <= wordData;
    end else if (stb.dabbleStep) begin
      bcd <= {bcdAdj[BW-2:0], bin[WORD_W-1]};
      bin <= {bin[WORD_W-2:0], 1'b0};
    end else if (stb.shiftDigit) begin
      bcd <= {bcd[BW-5:0], 4'd0};
    end
  end

  assign topDigit = bcd[BW-1 -: 4];

  // Transmitter
  logic [9:0]    txShift;
  logic [3:0]    txBits;
  logic [PW-1:0] txPhase;
  logic [7:0]    charByte;

  assign charByte = stb.sendCr ? 8'h0D : {4'h3, topDigit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '1;
      txBits  <= '0;
      txPhase <= '0;
      txBusy  <= 1'b0;
    end else if (stb.sendDigit || stb.sendCr) begin
      txShift <= {1'b1, charByte, 1'b0};
      txBits  <= 4'd10;
      txPhase <= '0;
      txBusy  <= 1'b1;
    end else if (txBusy && tick) begin
      if (txPhase == PW'(OVS - 1)) begin
        txPhase <= '0;
        txShift <= {1'b1, txShift[9:1]};
        txBits  <= txBits - 4'd1;
        if (txBits == 4'd1) txBusy <= 1'b0;
      end else begin
        txPhase <= txPhase + 1'b1;
      end
    end
  end

  assign txLine = txBusy ? txShift[0] : 1'b1;

  // Receiver for flow-control bytes
  logic          rxMeta, rxSync, rxActive;
  logic [PW-1:0] rxPhase;
  logic [3:0]    rxIdx;
  logic [7:0]    rxByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta   <= 1'b1;
      rxSync   <= 1'b1;
      rxActive <= 1'b0;
      rxPhase  <= '0;
      rxIdx    <= '0;
      rxByte   <= '0;
      flowOn   <= 1'b1;
    end else begin
      rxMeta <= rxLine;
      rxSync <= rxMeta;
      if (tick) begin
        if (!rxActive) begin
          if (!rxSync) begin
            rxActive <= 1'b1;
            rxPhase  <= '0;
            rxIdx    <= '0;
          end
        end else if (rxIdx == 4'd0) begin
          if (rxPhase == PW'(OVS / 2 - 1)) begin
            rxPhase <= '0;
            if (rxSync) rxActive <= 1'b0;
            else        rxIdx    <= 4'd1;
          end else begin
            rxPhase <= rxPhase + 1'b1;
          end
        end else if (rxPhase == PW'(OVS - 1)) begin
          rxPhase <= '0;
          if (rxIdx <= 4'd8) begin
            rxByte <= {rxSync, rxByte[7:1]};
            rxIdx  <= rxIdx + 4'd1;
          end else begin
            rxActive <= 1'b0;
            if (rxSync && rxByte == 8'h11) flowOn <= 1'b1;
            if (rxSync && rxByte == 8'h13) flowOn <= 1'b0;
          end
        end else begin
          rxPhase <= rxPhase + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/streamer_ctrl.sv
module streamer_ctrl
  import streamer_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int NDIG   = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wordValid,
  input  logic       wordLast,
  output logic       wordReady,
  input  logic       txBusy,
  input  logic       flowOn,
  input  logic [3:0] topDigit,
  output strobe_t    stb,
  output logic       done
);

  localparam int SW = $clog2(WORD_W + 1);
  localparam int DW = $clog2(NDIG + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_CONV, S_SKIP, S_DIGIT, S_CR, S_DRAIN, S_END
  } state_t;

  state_t        state;
  logic [SW-1:0] stepCnt;
  logic [DW-1:0] digLeft;
  logic          lastWord;
  logic          canSend;

  assign canSend   = !txBusy && flowOn;
  assign wordReady = (state == S_IDLE);
  assign done      = (state == S_END);

  always_comb begin
    stb = '0;
    case (state)
      S_IDLE:  stb.loadWord   = wordValid;
      S_CONV:  stb.dabbleStep = 1'b1;
      S_SKIP:  stb.shiftDigit = (topDigit == 4'd0) && (digLeft > DW'(1));
      S_DIGIT: begin
        stb.sendDigit  = canSend;
        stb.shiftDigit = canSend;
      end
      S_CR:    stb.sendCr = canSend;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      stepCnt  <= '0;
      digLeft  <= '0;
      lastWord <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (wordValid) begin
          lastWord <= wordLast;
          stepCnt  <= SW'(WORD_W);
          state    <= S_CONV;
        end
        S_CONV: begin
          stepCnt <= stepCnt - 1'b1;
          if (stepCnt == SW'(1)) begin
            digLeft <= DW'(NDIG);
            state   <= S_SKIP;
          end
        end
        S_SKIP:
          if (stb.shiftDigit) digLeft <= digLeft - 1'b1;
          else                state   <= S_DIGIT;
        S_DIGIT: if (canSend) begin
          digLeft <= digLeft - 1'b1;
          if (digLeft == DW'(1)) state <= S_CR;
        end
        S_CR: if (canSend) state <= lastWord ? S_DRAIN : S_IDLE;
        S_DRAIN: if (!txBusy) state <= S_END;
        default: state <= S_END;
      endcase
    end
  end

endmodule

// File: rtl/sample_streamer.sv
module sample_streamer
  import streamer_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000,
  parameter int BAUD   = 115_200,
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wordValid,
  input  logic [WORD_W-1:0] wordData,
  input  logic              wordLast,
  output logic              wordReady,
  input  logic              rxLine,
  output logic              txLine,
  output logic              done
);

  localparam int OVS      = 16;
  localparam int TICK_DIV = CLK_HZ / (BAUD * OVS);
  localparam int NDIG     = digitsFor(WORD_W);

  strobe_t    stb;
  logic       txBusy;
  logic       flowOn;
  logic [3:0] topDigit;

  streamer_ctrl #(.WORD_W(WORD_W), .NDIG(NDIG)) u_ctrl (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordLast(wordLast),
    .wordReady(wordReady), .txBusy(txBusy), .flowOn(flowOn),
    .topDigit(topDigit), .stb(stb), .done(done)
  );

  streamer_dp #(.WORD_W(WORD_W), .NDIG(NDIG), .TICK_DIV(TICK_DIV), .OVS(OVS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wordData(wordData), .rxLine(rxLine),
    .txLine(txLine), .txBusy(txBusy), .flowOn(flowOn), .topDigit(topDigit)
  );

endmodule

// File: rtl/streamer_checker.sv
module streamer_checker
  import streamer_pkg::*;
(
  input logic    clk,
  input logic    rstN,
  input strobe_t stb,
  input logic    txBusy,
  input logic    flowOn,
  input logic    txLine,
  input logic    wordValid,
  input logic    wordReady,
  input logic    done
);

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txLine);

  assert_start_low_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !txLine);

  assert_start_gated_R6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sendDigit || stb.sendCr) |-> (flowOn && !txBusy));

  assert_accept_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wordValid && wordReady) |=> !wordReady);

  assert_done_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> done);

  assert_done_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!wordReady && !txBusy && txLine));

endmodule

bind sample_streamer streamer_checker u_checker (
  .clk(clk), .rstN(rstN), .stb(stb), .txBusy(txBusy), .flowOn(flowOn),
  .txLine(txLine), .wordValid(wordValid), .wordReady(wordReady), .done(done)
);

// File: tb/sample_streamer_bench.sv
`timescale 1ns/1ps
module sample_streamer_bench;

  localparam int W    = 18;
  localparam int BITC = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wordValid = 1'b0;
  logic [W-1:0] wordData = '0;
  logic         wordLast = 1'b0;
  logic         wordReady;
  logic         rxLine = 1'b1;
  logic         txLine;
  logic         done;

  int checks = 0;
  int fails = 0;
  int charCount = 0;
  bit finished = 1'b0;
  logic [7:0] expQ[$];

  always #2.5 clk = ~clk;

  sample_streamer #(.CLK_HZ(1_600_000), .BAUD(100_000), .WORD_W(W)) u_sample_streamer (
    .clk(clk), .rstN(rstN), .wordValid(wordValid), .wordData(wordData),
    .wordLast(wordLast), .wordReady(wordReady), .rxLine(rxLine),
    .txLine(txLine), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Expected text for one word: decimal digits then CR
  function automatic void pushWord(input int unsigned v);
    logic [7:0] d[$];
    int unsigned x = v;
    if (x == 0) d.push_back(8'h30);
    while (x > 0) begin
      d.push_front(8'(8'h30 + x % 10));
      x = x / 10;
    end
    foreach (d[i]) expQ.push_back(d[i]);
    expQ.push_back(8'h0D);
  endfunction

  function automatic int textLen(input int unsigned v);
    int n = 1;
    int unsigned x = v;
    while (x >= 10) begin x = x / 10; n++; end
    return n + 1;
  endfunction

  task automatic sendWord(input int unsigned v, input bit last);
    pushWord(v);
    @(negedge clk);
    wordValid = 1'b1;
    wordData  = W'(v);
    wordLast  = last;
    while (!wordReady) @(negedge clk);
    @(negedge clk);
    wordValid = 1'b0;
    wordLast  = 1'b0;
  endtask

  task automatic sendRx(input logic [7:0] b);
    @(negedge clk);
    rxLine = 1'b0;
    repeat (BITC) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      rxLine = b[i];
      repeat (BITC) @(negedge clk);
    end
    rxLine = 1'b1;
    repeat (BITC) @(negedge clk);
  endtask

  task automatic waitDrain();
    int guard = 0;
    while (expQ.size() != 0 && guard < 40000) begin
      @(negedge clk);
      guard++;
    end
    repeat (20) @(negedge clk);
    check(expQ.size() == 0, "R5 all queued characters received", expQ.size(), 0);
  endtask

  // Serial monitor on the transmit line
  initial begin
    logic [7:0] b;
    logic [7:0] e;
    forever begin
      @(negedge clk);
      if (txLine === 1'b0) begin
        repeat (BITC/2) @(negedge clk);
        check(txLine === 1'b0, "R1 start bit held", txLine, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BITC) @(negedge clk);
          b[i] = txLine;
        end
        repeat (BITC) @(negedge clk);
        check(txLine === 1'b1, "R1/R6 stop bit", txLine, 1);
        charCount++;
        if (expQ.size() == 0) begin
          check(1'b0, "R5 unexpected character", b, -1);
        end else begin
          e = expQ.pop_front();
          check(b == e, (e == 8'h0D) ? "R4 carriage return" : "R2/R3 digit", b, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned v;
    int c0;
    int c1;
    v = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    check(txLine === 1'b1, "R12 txLine in reset", txLine, 1);
    check(done === 1'b0, "R12 done in reset", done, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(txLine === 1'b1, "R12 txLine after reset", txLine, 1);
    check(done === 1'b0, "R12 done after reset", done, 0);
    check(wordReady === 1'b1, "R12 wordReady after reset", wordReady, 1);

    // Directed values: output enabled straight from reset (R8)
    c0 = charCount;
    sendWord(0, 0);        // R3
    sendWord(2048, 0);     // R2 negative full scale pattern of 12 bits
    sendWord(262143, 0);   // R2 six digits
    sendWord(1, 0);
    sendWord(9, 0);
    sendWord(10, 0);
    sendWord(100000, 0);
    sendWord(99999, 0);
    waitDrain();
    check(charCount - c0 == 2+5+7+2+2+3+7+6, "R8 output from reset", charCount - c0, 34);

    // Random words of random bit length
    for (int k = 0; k < 40; k++) begin
      v = $urandom & ((32'd1 << ($urandom % (W + 1))) - 1);
      sendWord(v, 0);
    end
    waitDrain();

    // Pause from idle (R6), ignored byte (R9), glitch (R10), resume (R7)
    sendRx(8'h13);
    repeat (20) @(negedge clk);
    c0 = charCount;
    sendWord(12345, 0);
    repeat (1500) @(negedge clk);
    check(charCount == c0 && txLine === 1'b1, "R6 paused after XOFF", charCount - c0, 0);
    sendRx(8'h41);
    repeat (300) @(negedge clk);
    check(charCount == c0, "R9 other byte ignored", charCount - c0, 0);
    @(negedge clk);
    rxLine = 1'b0;
    repeat (3) @(negedge clk);
    rxLine = 1'b1;
    repeat (30) @(negedge clk);
    check(charCount == c0, "R10 glitch has no effect", charCount - c0, 0);
    sendRx(8'h11);
    waitDrain();
    check(charCount - c0 == textLen(12345), "R7 R10 resumed after XON", charCount - c0, textLen(12345));

    // Pause in mid stream: the running character completes (R6)
    sendWord(262143, 0);
    while (txLine !== 1'b0) @(negedge clk);
    sendRx(8'h13);
    repeat (200) @(negedge clk);
    c1 = charCount;
    check(c1 > 0 && expQ.size() > 0, "R6 in-progress character done", expQ.size(), 1);
    repeat (1000) @(negedge clk);
    check(charCount == c1, "R6 no new start during pause", charCount - c1, 0);
    sendRx(8'h11);
    waitDrain();

    // Final word and done flag (R11)
    check(done === 1'b0, "R11 done low before last word", done, 0);
    sendWord(305, 1);
    while (expQ.size() != 0) @(negedge clk);
    check(done === 1'b0, "R11 done low during last stop bit", done, 0);
    repeat (12) @(negedge clk);
    check(done === 1'b1, "R11 done after last CR", done, 1);
    check(wordReady === 1'b0, "R11 wordReady low after done", wordReady, 0);
    repeat (100) @(negedge clk);
    check(done === 1'b1 && wordReady === 1'b0, "R11 done sticky", done, 1);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule